// File: doc/BRIEF.md
# Look-Ahead FIFO Output Stage

This block is the read side of a synchronous FIFO running in look-ahead mode. It sits between a memory core, which shows its oldest word together with a valid strobe, and a consumer. Whenever its output register is vacant and the core holds data, the stage pulls a word on its own, so the oldest word is on the data output before any read is issued. The output register therefore counts as one more storage place, and the whole FIFO holds the core depth plus one word.

The stage keeps a word count that covers the core and the output register. A write is counted when the producer strobes it and room remains. A read is counted when the consumer strobes it and a word is on the output. From this count it derives five active-low or active-high status outputs: data present, no room, near empty, half full and near full. The near-empty and near-full thresholds come from offset inputs, and every threshold is one word above its standard-mode position because of the extra register.

The output register is controlled by a two-state machine. In state VACANT the register holds nothing. The FETCH transition (VACANT to LOADED) takes place when the core is valid. In state LOADED, the HOLD transition (stay in LOADED) applies with no read. The REFILL transition (stay in LOADED, new word popped) applies on a read while the core is valid. The DRAIN transition (LOADED to VACANT) applies on a read while the core is empty.

Top module: `fwft_stage`

## Requirements
- R1: After reset, q_avail_n_o is 1, no_room_o is 0, near_empty_n_o is 0, half_n_o is 1 and near_full_n_o is 1.
- R2: When the first word is written into an empty FIFO, it reaches the core on the write edge. The stage pops it on the next edge without any read, and from then q_avail_n_o is 0 and q_data_o shows that word.
- R3: The stage holds at most DEPTH+1 words. no_room_o is 1 exactly when DEPTH+1 words are held, and a write strobe while no_room_o is 1 is not counted.
- R4: A read strobe while q_avail_n_o is 1 changes neither the count nor the output.
- R5: A read while a word is on the output reloads q_data_o with the next core word on that edge if the core is valid. Otherwise q_avail_n_o goes to 1. Words leave in the order written.
- R6: A counted write and a counted read on the same edge leave the word count, and therefore every flag, unchanged.
- R7: near_empty_n_o is 0 while the count is at most ae_ofs_i+1, and 1 from ae_ofs_i+2 words.
- R8: half_n_o is 0 while the count is at least DEPTH/2+2, and 1 below that.
- R9: near_full_n_o is 0 while the count is at least DEPTH+1-af_ofs_i, and 1 below that (af_ofs_i at most DEPTH).
- R10: All count-based flags take their new value on the same clock edge that changes the count.
- R11: core_pop_o is only asserted while core_vld_i is 1. The popped word is taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Producer write strobe into the core |
| rd_en_i | input | 1 | Consumer read strobe |
| ae_ofs_i | input | OFS_W | Near-empty offset |
| af_ofs_i | input | OFS_W | Near-full offset |
| core_vld_i | input | 1 | Core has a word at its head |
| core_data_i | input | W | Core head word |
| core_pop_o | output | 1 | Take the head word from the core |
| q_data_o | output | W | Output register contents |
| q_avail_n_o | output | 1 | Low while a word is on the output |
| no_room_o | output | 1 | High while DEPTH+1 words are held |
| near_empty_n_o | output | 1 | Low while the count is at or below the near-empty threshold |
| half_n_o | output | 1 | Low while the count is at or above half plus two |
| near_full_n_o | output | 1 | Low while the count is at or above the near-full threshold |

## Verification
The bench builds the stage with DEPTH=16 and W=8. This puts the full count of 17, the half-full step at 10 and both offset thresholds within a few dozen cycles, so each boundary is crossed many times in both directions. The offsets are changed between phases, which moves the near-empty and near-full steps to other counts. A bench queue stands in for the core and pops only on the stage's request, so any wrong fetch shows up as a wrong word or a wrong order.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    typedef enum logic [0:0] {
        ST_VACANT = 1'b0,
        ST_LOADED = 1'b1
    } ostate_e;

    typedef enum logic [1:0] {
        LV_HOLD = 2'b00,
        LV_DEC  = 2'b01,
        LV_INC  = 2'b10,
        LV_BOTH = 2'b11
    } lvl_op_e;

endpackage

// File: rtl/fwft_out_ctrl.sv
module fwft_out_ctrl
    import fwft_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en_i,
    input  logic         core_vld_i,
    input  logic [W-1:0] core_data_i,
    output logic         core_pop_o,
    output logic         rd_take_o,
    output logic         q_avail_n_o,
    output logic [W-1:0] q_data_o
);

    ostate_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_VACANT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_VACANT: if (core_vld_i) st_d = ST_LOADED;                 // FETCH
            ST_LOADED: if (rd_en_i && !core_vld_i) st_d = ST_VACANT;     // DRAIN
            default:   st_d = ST_VACANT;
        endcase
    end

    // outputs
    always_comb begin
        core_pop_o = 1'b0;
        rd_take_o  = 1'b0;
        unique case (st_q)
            ST_VACANT: core_pop_o = core_vld_i;
            ST_LOADED: begin
                rd_take_o  = rd_en_i;
                core_pop_o = rd_en_i && core_vld_i;                       // REFILL
            end
            default: begin
                core_pop_o = 1'b0;
                rd_take_o  = 1'b0;
            end
        endcase
    end

    assign q_avail_n_o = (st_q != ST_LOADED);

    always_ff @(posedge clk) begin
        if (!rst_n)          q_data_o <= '0;
        else if (core_pop_o) q_data_o <= core_data_i;
    end

    p_pop_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        core_pop_o |-> core_vld_i);

    p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_avail_n_o && core_vld_i) |=> !q_avail_n_o);

    p_idle_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_avail_n_o && rd_en_i && !core_vld_i) |=> (q_avail_n_o && $stable(q_data_o)));

    p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_avail_n_o && rd_en_i && !core_vld_i) |=> q_avail_n_o);

    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_avail_n_o && rd_en_i && core_vld_i) |=> (!q_avail_n_o && q_data_o == $past(core_data_i)));

endmodule

// File: rtl/fwft_level.sv
module fwft_level
    import fwft_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int CNT_W = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_block_i,
    input  logic             rd_take_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    localparam int CAP = DEPTH + 1;

    logic    wr_take;
    lvl_op_e op;

    assign wr_take = wr_en_i && !wr_block_i;
    assign op      = lvl_op_e'({wr_take, rd_take_i});

    // single place where the count moves
    always_comb begin
        cnt_d_o = cnt_q_o;
        unique case (op)
            LV_INC:  cnt_d_o = cnt_q_o + 1'b1;
            LV_DEC:  cnt_d_o = cnt_q_o - 1'b1;
            LV_HOLD: cnt_d_o = cnt_q_o;
            LV_BOTH: cnt_d_o = cnt_q_o;
            default: cnt_d_o = cnt_q_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q_o <= '0;
        else        cnt_q_o <= cnt_d_o;
    end

    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q_o <= CNT_W'(CAP));

    p_full_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_block_i && !rd_take_i) |=> $stable(cnt_q_o));

    p_simul_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && rd_take_i) |=> $stable(cnt_q_o));

    p_idle_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_take && !rd_take_i) |=> $stable(cnt_q_o));

endmodule

// File: rtl/fwft_flags.sv
module fwft_flags #(
    parameter int DEPTH = 512,
    parameter int CNT_W = $clog2(DEPTH + 2),
    parameter int OFS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d_i,
    input  logic [CNT_W-1:0] cnt_q_i,
    input  logic [OFS_W-1:0] ae_ofs_i,
    input  logic [OFS_W-1:0] af_ofs_i,
    output logic             no_room_o,
    output logic             near_empty_n_o,
    output logic             half_n_o,
    output logic             near_full_n_o
);

    localparam int CAP      = DEPTH + 1;
    localparam int HALF_LVL = DEPTH / 2 + 2;
    localparam int CMP_W    = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

    logic [CMP_W-1:0] cnt_w, ae_lim, af_lim;

    assign cnt_w  = CMP_W'(cnt_d_i);
    assign ae_lim = CMP_W'(ae_ofs_i) + CMP_W'(1);
    assign af_lim = CMP_W'(CAP) - CMP_W'(af_ofs_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_room_o      <= 1'b0;
            near_empty_n_o <= 1'b0;
            half_n_o       <= 1'b1;
            near_full_n_o  <= 1'b1;
        end else begin
            no_room_o      <= (cnt_w == CMP_W'(CAP));
            near_empty_n_o <= (cnt_w > ae_lim);
            half_n_o       <= (cnt_w < CMP_W'(HALF_LVL));
            near_full_n_o  <= (cnt_w < af_lim);
        end
    end

    p_room_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cnt_q_i) |-> $stable(no_room_o) && $stable(half_n_o));

    p_empty_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q_i == '0) |-> !near_empty_n_o);

    p_full_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        no_room_o |-> !near_full_n_o);

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
    parameter int DEPTH = 512,
    parameter int W     = 18,
    parameter int OFS_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [OFS_W-1:0] ae_ofs_i,
    input  logic [OFS_W-1:0] af_ofs_i,
    input  logic             core_vld_i,
    input  logic [W-1:0]     core_data_i,
    output logic             core_pop_o,
    output logic [W-1:0]     q_data_o,
    output logic             q_avail_n_o,
    output logic             no_room_o,
    output logic             near_empty_n_o,
    output logic             half_n_o,
    output logic             near_full_n_o
);

    localparam int CNT_W = $clog2(DEPTH + 2);

    logic             rd_take;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    fwft_out_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (rd_en_i),
        .core_vld_i  (core_vld_i),
        .core_data_i (core_data_i),
        .core_pop_o  (core_pop_o),
        .rd_take_o   (rd_take),
        .q_avail_n_o (q_avail_n_o),
        .q_data_o    (q_data_o)
    );

    fwft_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_block_i (no_room_o),
        .rd_take_i  (rd_take),
        .cnt_q_o    (cnt_q),
        .cnt_d_o    (cnt_d)
    );

    fwft_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_d_i        (cnt_d),
        .cnt_q_i        (cnt_q),
        .ae_ofs_i       (ae_ofs_i),
        .af_ofs_i       (af_ofs_i),
        .no_room_o      (no_room_o),
        .near_empty_n_o (near_empty_n_o),
        .half_n_o       (half_n_o),
        .near_full_n_o  (near_full_n_o)
    );

endmodule

// File: tb/fwft_stage_tb.sv
`timescale 1ns/1ps
module fwft_stage_tb_top;

    localparam int DEPTH = 16;
    localparam int W     = 8;
    localparam int OFS_W = $clog2(DEPTH + 1);
    localparam int CAP   = DEPTH + 1;
    localparam int HALF  = DEPTH / 2 + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [OFS_W-1:0] ae_ofs = OFS_W'(3), af_ofs = OFS_W'(2);
    logic             core_vld = 1'b0;
    logic [W-1:0]     core_data = '0;
    logic             core_pop;
    logic [W-1:0]     q_data;
    logic             q_avail_n, no_room, near_empty_n, half_n, near_full_n;

    int tests = 0, fails = 0;

    logic [W-1:0] core_q[$];
    logic [W-1:0] ref_q[$];
    int           exp_cnt = 0;
    bit           exp_ov = 0;
    logic [W-1:0] exp_od = '0;
    logic [W-1:0] wdata = 8'h01;

    always #10 clk = ~clk;

    fwft_stage #(.DEPTH(DEPTH), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
        .core_vld_i(core_vld), .core_data_i(core_data), .core_pop_o(core_pop),
        .q_data_o(q_data), .q_avail_n_o(q_avail_n), .no_room_o(no_room),
        .near_empty_n_o(near_empty_n), .half_n_o(half_n), .near_full_n_o(near_full_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_near_empty_n(int c, int ae);  return !(c <= ae + 1);   endfunction
    function automatic bit f_half_n(int c);                return !(c >= HALF);     endfunction
    function automatic bit f_near_full_n(int c, int af);   return !(c >= CAP - af); endfunction

    task automatic check_all(input bit both);
        chk("R2 R5 q_avail_n", q_avail_n, !exp_ov);
        if (exp_ov) chk("R5 q_data order", q_data, exp_od);
        chk(both ? "R6 no_room" : "R3 no_room", no_room, exp_cnt == CAP);
        chk(both ? "R6 near_empty_n" : "R7 near_empty_n", near_empty_n, f_near_empty_n(exp_cnt, int'(ae_ofs)));
        chk("R8 R10 half_n", half_n, f_half_n(exp_cnt));
        chk("R9 R10 near_full_n", near_full_n, f_near_full_n(exp_cnt, int'(af_ofs)));
    endtask

    task automatic step(input bit w, input bit r);
        bit wacc, racc, dpop;
        @(negedge clk);
        wr_en = w;
        rd_en = r;
        #1;
        dpop = core_pop;
        wacc = w && (exp_cnt < CAP);
        racc = r && exp_ov;
        if (dpop) chk("R11 pop with core valid", core_vld, 1);
        @(posedge clk);
        #1;
        // core model follows the stage's pop request
        if (dpop && core_q.size() > 0) void'(core_q.pop_front());
        // reference model from the requirements
        if (!exp_ov) begin
            if (ref_q.size() > 0) begin exp_od = ref_q.pop_front(); exp_ov = 1; end
        end else if (racc) begin
            if (ref_q.size() > 0) exp_od = ref_q.pop_front();
            else exp_ov = 0;
        end
        if (wacc) begin
            core_q.push_back(wdata);
            ref_q.push_back(wdata);
            wdata = wdata + 1'b1;
        end
        exp_cnt = exp_cnt + int'(wacc) - int'(racc);
        core_vld  = core_q.size() > 0;
        core_data = (core_q.size() > 0) ? core_q[0] : '0;
        check_all(wacc && racc);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 q_avail_n", q_avail_n, 1);
        chk("R1 no_room", no_room, 0);
        chk("R1 near_empty_n", near_empty_n, 0);
        chk("R1 half_n", half_n, 1);
        chk("R1 near_full_n", near_full_n, 1);

        // R4 read on empty ignored
        step(0, 1);
        step(0, 1);
        // R2 fall-through of a single word
        step(1, 0);
        chk("R2 not yet on output", q_avail_n, 1);
        step(0, 0);
        chk("R2 word fell through", q_data, 8'h01);
        // R5 drain
        step(0, 1);
        chk("R5 drained", q_avail_n, 1);

        // R3 fill past capacity
        for (int i = 0; i < CAP + 4; i++) step(1, 0);
        chk("R3 full", no_room, 1);
        step(1, 0);
        step(1, 0);
        // R6 write and read together at full
        step(1, 1);
        step(1, 1);
        // drain fully, then extra reads (R4)
        for (int i = 0; i < CAP + 4; i++) step(0, 1);
        chk("R4 empty after drain", q_avail_n, 1);

        // random phases with different offsets
        for (int ph = 0; ph < 3; ph++) begin
            ae_ofs = OFS_W'(ph * 2);
            af_ofs = OFS_W'(ph * 3 + 1);
            for (int i = 0; i < 900; i++) begin
                int bias;
                bias = (i / 150) % 3;
                case (bias)
                    0: step(($urandom % 4) != 0, ($urandom % 4) == 0);
                    1: step(($urandom % 4) == 0, ($urandom % 4) != 0);
                    default: step($urandom % 2 == 1, $urandom % 2 == 1);
                endcase
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule